// File: doc/BRIEF.md
# Debug Access Request Handler

This block sits behind a test access port and turns each scanned debug access into a transaction on a simple request/response bus to the debug registers. When the port finishes an Update-DR, the block receives the whole shifted vector. It splits the vector into a 2-bit operation, a 32-bit data word and an address. For a read or a write, it issues one request on the bus and waits for the response.

The block keeps a stored access vector. When the port pulses capture, the block copies the stored vector into an output register, and the port shifts that register out on the next scan. The low two bits of the stored vector hold a completion status in place of the operation. A read that succeeds also puts the returned word into the data field. While a bus access is still in flight, a capture reports busy. An update that arrives while an access is in flight is discarded, so the host must scan again.

Top module: `dmi_req_handler`

## Requirements
- R1: The update vector is decoded as follows. The operation is bits [1:0], the data word is bits [33:2], and the address is bits [ABITS+33:34]. A bus request carries that address and that data word.
- R2: After reset, a capture returns all-zero address and data fields with status 2 (failed), and no request is pending.
- R3: Operation code 0 (no-op) and code 3 (reserved) issue no bus request. They store the vector's address and data unchanged and report status 0 (success).
- R4: Operation code 1 (read) issues one request with req_write low. A response without error puts rsp_rdata into the data field and sets status 0.
- R5: Operation code 2 (write) issues one request with req_write high and the vector's data. After an error-free response, the data field keeps the written word and the status is 0.
- R6: A response with rsp_err high sets status 2 and leaves the data field as it was scanned in. Status code 1 is never reported.
- R7: A capture taken while a request is outstanding returns status 3 (busy) together with the address and data of the pending access.
- R8: An update that arrives while a request is outstanding is ignored. It issues no new request and does not change the stored vector.
- R9: Once req_valid is high, it stays high with stable req_write, req_addr and req_wdata until req_ready is seen.
- R10: If a capture and the bus response fall in the same cycle, the capture returns busy. The completed result appears at the next capture.
- R11: cap_vec changes only in the cycle after cap_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update-DR strobe for the access register |
| upd_vec | input | ABITS+34 | Vector shifted in by the port |
| cap_req | input | 1 | Capture-DR strobe |
| cap_vec | output | ABITS+34 | Vector to shift out on the next scan |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request accepted |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ABITS | Register address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Bus response valid |
| rsp_rdata | input | 32 | Read data returned |
| rsp_err | input | 1 | Access failed |

## Verification
Completing a bus response and taking a capture snapshot can fall on the same clock edge. The snapshot must then show the state from before the edge, which is busy, and the result must appear only at the following capture. The bench provokes this collision by having its bus responder raise cap_req in exactly the cycle in which it drives rsp_valid. It then checks both captures against a behavioural model that is stepped every clock. The same model also covers updates dropped during a stall or during a slow response.

// File: rtl/dmi_req_pkg.sv
package dmi_req_pkg;
    localparam int DATA_W = 32;
    localparam int OP_W   = 2;

    typedef enum logic [1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } dmi_op_e;

    typedef enum logic [1:0] {
        ST_OK   = 2'd0,
        ST_RSVD = 2'd1,
        ST_FAIL = 2'd2,
        ST_BUSY = 2'd3
    } dmi_st_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_REQ  = 2'd1,
        BUS_WAIT = 2'd2
    } bus_state_e;

    function automatic logic op_uses_bus(dmi_op_e op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction
endpackage

// File: rtl/dmi_req_decode.sv
module dmi_req_decode
    import dmi_req_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic [ABITS+DATA_W+OP_W-1:0] vec_i,
    output dmi_op_e                      op_o,
    output logic [DATA_W-1:0]            data_o,
    output logic [ABITS-1:0]             addr_o,
    output logic                         access_o
);
    localparam int DATA_LSB = OP_W;
    localparam int ADDR_LSB = OP_W + DATA_W;

    always_comb begin
        op_o     = dmi_op_e'(vec_i[OP_W-1:0]);
        data_o   = vec_i[DATA_LSB +: DATA_W];
        addr_o   = vec_i[ADDR_LSB +: ABITS];
        access_o = op_uses_bus(op_o);
    end
endmodule

// File: rtl/dmi_req_bus.sv
module dmi_req_bus
    import dmi_req_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_write_i,
    input  logic [ABITS-1:0]  start_addr_i,
    input  logic [DATA_W-1:0] start_data_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic              req_write_o,
    output logic [ABITS-1:0]  req_addr_o,
    output logic [DATA_W-1:0] req_wdata_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_rdata_i,
    input  logic              rsp_err_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              done_err_o,
    output logic [DATA_W-1:0] done_data_o
);
    typedef struct packed {
        bus_state_e        state;
        logic              write;
        logic [ABITS-1:0]  addr;
        logic [DATA_W-1:0] wdata;
    } bus_regs_t;

    bus_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            BUS_IDLE: begin
                if (start_i) begin
                    d.state = BUS_REQ;
                    d.write = start_write_i;
                    d.addr  = start_addr_i;
                    d.wdata = start_data_i;
                end
            end
            BUS_REQ: begin
                if (req_ready_i) begin
                    d.state = BUS_WAIT;
                end
            end
            BUS_WAIT: begin
                if (rsp_valid_i) begin
                    d.state = BUS_IDLE;
                end
            end
            default: d.state = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: BUS_IDLE, write: 1'b0, addr: '0, wdata: '0};
        end else begin
            q <= d;
        end
    end

    assign req_valid_o = (q.state == BUS_REQ);
    assign req_write_o = q.write;
    assign req_addr_o  = q.addr;
    assign req_wdata_o = q.wdata;
    assign busy_o      = (q.state != BUS_IDLE);
    assign done_o      = (q.state == BUS_WAIT) && rsp_valid_i;
    assign done_err_o  = rsp_err_i;
    assign done_data_o = rsp_rdata_i;
endmodule

// File: rtl/dmi_req_result.sv
module dmi_req_result
    import dmi_req_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  dmi_op_e                       load_op_i,
    input  logic [ABITS-1:0]              load_addr_i,
    input  logic [DATA_W-1:0]             load_data_i,
    input  logic                          done_i,
    input  logic                          done_err_i,
    input  logic [DATA_W-1:0]             done_data_i,
    input  logic                          busy_i,
    input  logic                          cap_i,
    output logic [ABITS+DATA_W+OP_W-1:0]  cap_vec_o
);
    localparam int VEC_W = ABITS + DATA_W + OP_W;

    typedef struct packed {
        logic [ABITS-1:0]  addr;
        logic [DATA_W-1:0] data;
        dmi_st_e           status;
        logic              rd_pend;
        logic [VEC_W-1:0]  cap;
    } res_regs_t;

    res_regs_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.addr    = load_addr_i;
            d.data    = load_data_i;
            d.status  = ST_OK;
            d.rd_pend = (load_op_i == OP_READ);
        end
        if (done_i) begin
            d.status  = done_err_i ? ST_FAIL : ST_OK;
            if (!done_err_i && q.rd_pend) begin
                d.data = done_data_i;
            end
            d.rd_pend = 1'b0;
        end
        if (cap_i) begin
            d.cap = {q.addr, q.data, (busy_i ? ST_BUSY : q.status)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{addr: '0, data: '0, status: ST_FAIL, rd_pend: 1'b0,
                   cap: {{(VEC_W-OP_W){1'b0}}, ST_FAIL}};
        end else begin
            q <= d;
        end
    end

    assign cap_vec_o = q.cap;
endmodule

// File: rtl/dmi_req_handler.sv
module dmi_req_handler
    import dmi_req_pkg::*;
#(
    parameter int ABITS = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         upd_valid,
    input  logic [ABITS+DATA_W+OP_W-1:0] upd_vec,
    input  logic                         cap_req,
    output logic [ABITS+DATA_W+OP_W-1:0] cap_vec,
    output logic                         req_valid,
    input  logic                         req_ready,
    output logic                         req_write,
    output logic [ABITS-1:0]             req_addr,
    output logic [DATA_W-1:0]            req_wdata,
    input  logic                         rsp_valid,
    input  logic [DATA_W-1:0]            rsp_rdata,
    input  logic                         rsp_err
);
    dmi_op_e           dec_op;
    logic [DATA_W-1:0] dec_data;
    logic [ABITS-1:0]  dec_addr;
    logic              dec_access;
    logic              busy;
    logic              accept;
    logic              done;
    logic              done_err;
    logic [DATA_W-1:0] done_data;

    dmi_req_decode #(.ABITS(ABITS)) i_decode (
        .vec_i    (upd_vec),
        .op_o     (dec_op),
        .data_o   (dec_data),
        .addr_o   (dec_addr),
        .access_o (dec_access)
    );

    assign accept = upd_valid && !busy;

    dmi_req_bus #(.ABITS(ABITS)) i_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (accept && dec_access),
        .start_write_i (dec_op == OP_WRITE),
        .start_addr_i  (dec_addr),
        .start_data_i  (dec_data),
        .req_valid_o   (req_valid),
        .req_ready_i   (req_ready),
        .req_write_o   (req_write),
        .req_addr_o    (req_addr),
        .req_wdata_o   (req_wdata),
        .rsp_valid_i   (rsp_valid),
        .rsp_rdata_i   (rsp_rdata),
        .rsp_err_i     (rsp_err),
        .busy_o        (busy),
        .done_o        (done),
        .done_err_o    (done_err),
        .done_data_o   (done_data)
    );

    dmi_req_result #(.ABITS(ABITS)) i_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .load_op_i   (dec_op),
        .load_addr_i (dec_addr),
        .load_data_i (dec_data),
        .done_i      (done),
        .done_err_i  (done_err),
        .done_data_i (done_data),
        .busy_i      (busy),
        .cap_i       (cap_req),
        .cap_vec_o   (cap_vec)
    );
endmodule

// File: rtl/dmi_req_handler_chk.sv
module dmi_req_handler_chk #(
    parameter int ABITS = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             upd_valid,
    input logic [ABITS+33:0] upd_vec,
    input logic             cap_req,
    input logic [ABITS+33:0] cap_vec,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic [ABITS-1:0] req_addr,
    input logic [31:0]      req_wdata,
    input logic             rsp_valid,
    input logic             busy
);
    localparam int ADDR_LSB = 34;

    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
                                    && $stable(req_write) && $stable(req_wdata));

    p_idle_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !busy && (upd_vec[1:0] == 2'd0 || upd_vec[1:0] == 2'd3)
        |=> !req_valid);

    p_read_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !busy && upd_vec[1:0] == 2'd1
        |=> req_valid && !req_write && req_addr == $past(upd_vec[ADDR_LSB +: ABITS]));

    p_write_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && !busy && upd_vec[1:0] == 2'd2
        |=> req_valid && req_write && req_wdata == $past(upd_vec[33:2]));

    p_busy_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req && busy |=> cap_vec[1:0] == 2'd3);

    p_rsp_cap_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req && busy && !req_valid && rsp_valid |=> cap_vec[1:0] == 2'd3);

    p_cap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_req |=> $stable(cap_vec));

    p_drop_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !req_valid && upd_valid && !rsp_valid |=> !req_valid);

    p_no_rsvd_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vec[1:0] != 2'd1);
endmodule

bind dmi_req_handler dmi_req_handler_chk #(.ABITS(ABITS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_vec   (upd_vec),
    .cap_req   (cap_req),
    .cap_vec   (cap_vec),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .busy      (busy)
);

// File: tb/test_dmi_req_handler.sv
module test_dmi_req_handler;
    localparam int AB = 7;
    localparam int VW = AB + 34;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          upd_valid = 1'b0;
    logic [VW-1:0] upd_vec = '0;
    logic          cap_task = 1'b0;
    logic          cap_auto = 1'b0;
    wire           cap_req = cap_task | cap_auto;
    logic [VW-1:0] cap_vec;
    logic          req_valid, req_write;
    logic          req_ready = 1'b0;
    logic [AB-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid = 1'b0;
    logic [31:0]   rsp_rdata = '0;
    logic          rsp_err = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    dmi_req_handler #(.ABITS(AB)) i_dmi_req_handler (
        .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_vec(upd_vec),
        .cap_req(cap_req), .cap_vec(cap_vec), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] mk(input logic [1:0] op, input logic [31:0] dat,
                                          input logic [AB-1:0] adr);
        return {adr, dat, op};
    endfunction

    // ---------------- bus responder ----------------
    logic [31:0] mem [128];
    int  rsp_delay = 0;
    int  stall_cfg = 0;
    int  stall_left = 0;
    bit  cap_on_rsp = 1'b0;
    bit  hs_pend = 1'b0;
    int  hs_wait = 0;
    bit  hs_wr = 1'b0;
    logic [AB-1:0] hs_addr = '0;
    logic [31:0]   hs_data = '0;
    int  hs_count = 0;

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 32'h1000_0000 + 32'(i * 3);
    end

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        cap_auto  = 1'b0;
        if (hs_pend) begin
            if (hs_wait == 0) begin
                rsp_valid = 1'b1;
                rsp_err   = (hs_addr >= 7'h70);
                rsp_rdata = hs_wr ? 32'h0 : mem[hs_addr];
                if (hs_wr && !rsp_err) mem[hs_addr] = hs_data;
                cap_auto  = cap_on_rsp;
                hs_pend   = 1'b0;
            end else begin
                hs_wait--;
            end
        end
        req_ready = 1'b0;
        if (req_valid && rst_n) begin
            if (stall_left > 0) begin
                stall_left--;
            end else begin
                req_ready  = 1'b1;
                hs_pend    = 1'b1;
                hs_wait    = rsp_delay;
                hs_wr      = req_write;
                hs_addr    = req_addr;
                hs_data    = req_wdata;
                hs_count++;
                stall_left = stall_cfg;
            end
        end
    end

    // ---------------- behavioural reference ----------------
    bit            m_pend, m_acc, m_wr, m_rd;
    logic [AB-1:0] m_addr;
    logic [31:0]   m_data;
    logic [1:0]    m_st;
    logic [VW-1:0] m_cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_acc = 0; m_wr = 0; m_rd = 0;
            m_addr = '0; m_data = '0; m_st = 2'd2;
            m_cap  = mk(2'd2, 32'h0, '0);
        end else begin
            automatic bit was_pend = m_pend;
            if (cap_req) m_cap = mk(m_pend ? 2'd3 : m_st, m_data, m_addr);
            if (m_pend && !m_acc && req_ready) begin
                m_acc = 1;
            end else if (m_pend && m_acc && rsp_valid) begin
                m_st = rsp_err ? 2'd2 : 2'd0;
                if (m_rd && !rsp_err) m_data = rsp_rdata;
                m_pend = 0; m_acc = 0;
            end
            if (!was_pend && upd_valid) begin
                m_addr = upd_vec[40:34];
                m_data = upd_vec[33:2];
                m_st   = 2'd0;
                m_rd   = (upd_vec[1:0] == 2'd1);
                m_wr   = (upd_vec[1:0] == 2'd2);
                m_pend = m_rd || m_wr;
                m_acc  = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cap_vec == m_cap, "R11 capture vector", 64'(cap_vec), 64'(m_cap));
            chk(req_valid == (m_pend && !m_acc), "R9 request valid",
                64'(req_valid), 64'(m_pend && !m_acc));
            if (req_valid)
                chk({req_write, req_addr, req_wdata} == {m_wr, m_addr, m_data},
                    "R1 request fields", 64'({req_write, req_addr, req_wdata}),
                    64'({m_wr, m_addr, m_data}));
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_update(input logic [VW-1:0] v);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_vec   = v;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 200 && m_pend; k++) @(negedge clk);
    endtask

    task automatic cap_check(input logic [VW-1:0] exp, input string tag);
        @(negedge clk);
        cap_task = 1'b1;
        @(negedge clk);
        cap_task = 1'b0;
        chk(cap_vec == exp, tag, 64'(cap_vec), 64'(exp));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cap_vec == mk(2'd2, 32'h0, 7'h0), "R2 reset vector", 64'(cap_vec),
            64'(mk(2'd2, 32'h0, 7'h0)));
        chk(req_valid == 1'b0, "R2 no request after reset", 64'(req_valid), 64'h0);
        cap_check(mk(2'd2, 32'h0, 7'h0), "R2 capture after reset");

        // write then read back
        do_update(mk(2'd2, 32'hA5A5_0001, 7'h05));
        wait_idle();
        cap_check(mk(2'd0, 32'hA5A5_0001, 7'h05), "R5 write result");
        do_update(mk(2'd1, 32'h0000_1234, 7'h05));
        wait_idle();
        cap_check(mk(2'd0, 32'hA5A5_0001, 7'h05), "R4 read result");

        // no-op and reserved
        hs0 = hs_count;
        do_update(mk(2'd0, 32'h0000_DEAD, 7'h09));
        cap_check(mk(2'd0, 32'h0000_DEAD, 7'h09), "R3 no-op result");
        do_update(mk(2'd3, 32'h0000_BEEF, 7'h0A));
        cap_check(mk(2'd0, 32'h0000_BEEF, 7'h0A), "R3 reserved result");
        chk(hs_count == hs0, "R3 no bus request", 64'(hs_count), 64'(hs0));

        // errors
        do_update(mk(2'd1, 32'h0000_1111, 7'h71));
        wait_idle();
        cap_check(mk(2'd2, 32'h0000_1111, 7'h71), "R6 read error");
        do_update(mk(2'd2, 32'h0000_2222, 7'h72));
        wait_idle();
        cap_check(mk(2'd2, 32'h0000_2222, 7'h72), "R6 write error");

        // busy capture and dropped update
        rsp_delay = 6;
        do_update(mk(2'd1, 32'h0000_0055, 7'h20));
        cap_check(mk(2'd3, 32'h0000_0055, 7'h20), "R7 busy capture");
        hs0 = hs_count;
        do_update(mk(2'd2, 32'h0000_0077, 7'h21));
        wait_idle();
        cap_check(mk(2'd0, 32'h1000_0060, 7'h20), "R8 update dropped");
        chk(hs_count == hs0, "R8 no second request", 64'(hs_count), 64'(hs0));
        chk(mem[33] == 32'h1000_0063, "R8 memory untouched", 64'(mem[33]), 64'h1000_0063);

        // capture collides with response
        rsp_delay  = 2;
        cap_on_rsp = 1'b1;
        do_update(mk(2'd1, 32'h0000_0003, 7'h03));
        wait_idle();
        cap_on_rsp = 1'b0;
        chk(cap_vec == mk(2'd3, 32'h0000_0003, 7'h03), "R10 collision capture busy",
            64'(cap_vec), 64'(mk(2'd3, 32'h0000_0003, 7'h03)));
        cap_check(mk(2'd0, 32'h1000_0009, 7'h03), "R10 result on next capture");

        // stalled request
        rsp_delay = 1;
        stall_cfg = 3;
        stall_left = 3;
        do_update(mk(2'd2, 32'hCAFE_0030, 7'h30));
        wait_idle();
        cap_check(mk(2'd0, 32'hCAFE_0030, 7'h30), "R9 stalled write");
        do_update(mk(2'd1, 32'h0, 7'h30));
        wait_idle();
        cap_check(mk(2'd0, 32'hCAFE_0030, 7'h30), "R4 read after stalled write");

        // random traffic checked by the per-cycle model
        void'($urandom(7));
        for (int n = 0; n < 80; n++) begin
            rsp_delay = int'($urandom % 4);
            stall_cfg = int'($urandom % 3);
            do_update(mk(2'($urandom), $urandom, 7'($urandom)));
            if ($urandom % 2 == 0) begin
                @(negedge clk); cap_task = 1'b1;
                @(negedge clk); cap_task = 1'b0;
            end
            if ($urandom % 3 != 0) wait_idle();
        end
        wait_idle();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule